// File: doc/BRIEF.md
# Tag command and protection controller

This block sits behind the receive path of a contactless tag. The receiver has already removed the framing and checked the CRC. It passes on a stream of bytes, then a pulse that marks a clean end of frame or a pulse that marks a damaged frame. The controller decodes the first byte of each frame as a command and the bytes after it as operands. It then applies the command to a model of tag memory: ten pages of 32 bits each. Pages 0–7 are user pages, page 8 holds the lock and option bits, and page 9 holds the password.

Before any memory write, the controller enforces the protection rules. Each user page has a sticky lock bit. The option page and the password page each have their own freeze bit. An optional password gate can be opened for the rest of the session. A lock update is allowed only after a page write has succeeded. For every accepted frame, the block selects the reply the transmitter sends next. The reply is one of: the accessed page repeated, a one-byte acknowledge, a return to ID transmission, or silence. It also emits a write strobe with page and data for every memory update.

Top module: `tag_cmd_ctrl`

## Requirements
- R1: After reset, reply_kind is 0 (ID), reply_page is 0, wr_stb is low, and every page of memory reads as zero.
- R2: A frame holding only the byte 0x80|a selects page a for reply (reply_kind 1) when a is 0–8. reply_data carries the contents of page a from the cycle after rx_end. A read of page 9 is refused.
- R3: A frame holding 0x40|a (a 0–7) and four data bytes writes those bytes to page a. The first data byte lands in bits 7:0. wr_stb pulses for one cycle, and the reply becomes page a. The write is refused while bit a of page 8 is set.
- R4: The frame 0xC0, L, 0xAA, 0xAA, 0xAA ORs L into page 8 bits 7:0 and replies with page 8. It is executed only if a page write has succeeded since reset. A lock bit, once set, is never cleared.
- R5: The frame 0xC8, 0xAA, X, Y, Z replaces page 8 bits 31:8 with Z:Y:X and keeps bits 7:0. It replies with page 8. It is refused while page 8 bit 11 is set.
- R6: The frame 0xE0 plus four bytes writes page 9 and replies with acknowledge (reply_kind 2). It is refused while page 8 bit 10 is set.
- R7: While the password gate is active, reads, page writes and the lock, option and password writes are refused. The frame 0x38 plus four bytes equal to page 9 opens the gate for the session and replies with acknowledge. A mismatch is refused.
- R8: The gate uses a copy of page 8 bit 8. That copy is taken at reset and again at every illegal command, so writing the option page does not change the gate until then.
- R9: An unknown opcode, a wrong operand count, a filler byte other than 0xAA, a read address of 10–15, or an empty frame is illegal. It writes nothing and sets the reply to ID.
- R10: A frame ended by rx_bad is discarded. It causes no write, and the reply does not change.
- R11: The frame 0x18 sets reply_kind to 3 (silent). Every later frame is ignored until reset.
- R12: A refused command writes nothing and leaves the reply unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| rx_vld | input | 1 | rx_byte is valid this cycle |
| rx_end | input | 1 | Clean end of the current frame |
| rx_bad | input | 1 | Current frame is damaged; discard it |
| reply_kind | output | 2 | 0 ID, 1 page, 2 acknowledge, 3 silent |
| reply_page | output | 4 | Page to repeat when reply_kind is 1 |
| reply_data | output | 32 | Contents of reply_page when reply_kind is 1, else zero |
| wr_stb | output | 1 | One-cycle memory write strobe |
| wr_page | output | 4 | Page written with the last strobe |
| wr_data | output | 32 | Data written with the last strobe |

## Verification
The command decoder is driven with well-formed frames for every opcode, and each one is tried both with its permission met and with it not met. This separates a refusal (reply held) from an illegal command (reply set to ID). Malformed variants are also sent: an extra operand, a missing operand, a wrong filler byte, an out-of-range read address and a damaged frame. These show that length and filler checks run before any write. Ordered sequences test the state that carries across frames: a lock write before and after the first page write, an option write followed by an illegal command that arms the gate, and the freeze bits set one after the other.

// File: rtl/tagctl_pkg.sv
package tagctl_pkg;
  localparam int PAGE_W   = 32;
  localparam int PAGE_AW  = 4;
  localparam int CFG_PAGE = 8;
  localparam int PW_PAGE  = 9;

  // option bit positions inside the configuration page
  localparam int GATE_BIT       = 8;
  localparam int PW_FREEZE_BIT  = 10;
  localparam int CFG_FREEZE_BIT = 11;

  localparam logic [7:0] OP_WLOCK = 8'hC0;
  localparam logic [7:0] OP_WCFG  = 8'hC8;
  localparam logic [7:0] OP_WPW   = 8'hE0;
  localparam logic [7:0] OP_HALT  = 8'h18;
  localparam logic [7:0] OP_CHKPW = 8'h38;
  localparam logic [7:0] FILLER   = 8'hAA;

  typedef enum logic [1:0] {
    RPL_ID     = 2'd0,
    RPL_PAGE   = 2'd1,
    RPL_ACK    = 2'd2,
    RPL_SILENT = 2'd3
  } reply_e;

  typedef struct packed {
    logic               legal;
    logic               wr;
    logic [PAGE_AW-1:0] wpage;
    logic [PAGE_W-1:0]  wdata;
    logic               upd_reply;
    reply_e             rkind;
    logic [PAGE_AW-1:0] rpage;
    logic               open_gate;
    logic               mark_wr;
    logic               halt;
  } verdict_t;
endpackage

// File: rtl/tag_frame_collect.sv
module tag_frame_collect #(
  parameter int DBYTES = 4,
  localparam int CW    = $clog2(DBYTES + 3)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          rx_byte,
  input  logic                rx_vld,
  input  logic                rx_end,
  input  logic                rx_bad,
  output logic                has_cmd,
  output logic [7:0]          cmd,
  output logic [8*DBYTES-1:0] data,
  output logic [CW-1:0]       ndata
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DBYTES + 2);

  logic [CW-1:0]       cnt_q, cnt_n;
  logic [7:0]          cmd_q, cmd_n;
  logic [8*DBYTES-1:0] data_q, data_n;

  always_comb begin
    cnt_n  = cnt_q;
    cmd_n  = cmd_q;
    data_n = data_q;
    if (rx_end || rx_bad) begin
      cnt_n  = '0;
      data_n = '0;
    end else if (rx_vld) begin
      if (cnt_q == '0) cmd_n = rx_byte;
      for (int i = 0; i < DBYTES; i++)
        if (cnt_q == CW'(i + 1)) data_n[8*i +: 8] = rx_byte;
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      cmd_q  <= cmd_n;
      data_q <= data_n;
    end
  end

  assign has_cmd = (cnt_q != '0);
  assign cmd     = cmd_q;
  assign data    = data_q;
  assign ndata   = has_cmd ? cnt_q - 1'b1 : '0;

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/tag_cmd_judge.sv
module tag_cmd_judge
  import tagctl_pkg::*;
#(
  parameter int NPAGES = 10,
  parameter int CW     = 3
) (
  input  logic              has_cmd,
  input  logic [7:0]        cmd,
  input  logic [PAGE_W-1:0] data,
  input  logic [CW-1:0]     ndata,
  input  logic [PAGE_W-1:0] cfg_word,
  input  logic [PAGE_W-1:0] pw_word,
  input  logic              gate_on,
  input  logic              pw_ok,
  input  logic              wr_seen,
  output verdict_t          v
);
  localparam logic [CW-1:0] FULL = CW'(PAGE_W / 8);

  logic gate_open, n0, n4;

  always_comb begin
    gate_open = !gate_on || pw_ok;
    n0 = (ndata == '0);
    n4 = (ndata == FULL);
    v = '0;
    v.legal = 1'b1;
    v.rkind = RPL_ID;
    if (!has_cmd) begin
      v.legal = 1'b0;
    end else if (cmd[7:4] == 4'b1000 && n0) begin
      if (32'(cmd[3:0]) >= NPAGES) v.legal = 1'b0;
      else if (32'(cmd[3:0]) != PW_PAGE && gate_open) begin
        v.upd_reply = 1'b1;
        v.rkind     = RPL_PAGE;
        v.rpage     = cmd[3:0];
      end
    end else if (cmd[7:3] == 5'b01000 && n4) begin
      if (gate_open && !cfg_word[cmd[2:0]]) begin
        v.wr        = 1'b1;
        v.wpage     = {1'b0, cmd[2:0]};
        v.wdata     = data;
        v.mark_wr   = 1'b1;
        v.upd_reply = 1'b1;
        v.rkind     = RPL_PAGE;
        v.rpage     = {1'b0, cmd[2:0]};
      end
    end else if (cmd == OP_WLOCK && n4 && data[31:8] == {3{FILLER}}) begin
      if (gate_open && wr_seen) begin
        v.wr        = 1'b1;
        v.wpage     = PAGE_AW'(CFG_PAGE);
        v.wdata     = cfg_word | {24'h0, data[7:0]};
        v.upd_reply = 1'b1;
        v.rkind     = RPL_PAGE;
        v.rpage     = PAGE_AW'(CFG_PAGE);
      end
    end else if (cmd == OP_WCFG && n4 && data[7:0] == FILLER) begin
      if (gate_open && !cfg_word[CFG_FREEZE_BIT]) begin
        v.wr        = 1'b1;
        v.wpage     = PAGE_AW'(CFG_PAGE);
        v.wdata     = {data[31:8], cfg_word[7:0]};
        v.upd_reply = 1'b1;
        v.rkind     = RPL_PAGE;
        v.rpage     = PAGE_AW'(CFG_PAGE);
      end
    end else if (cmd == OP_WPW && n4) begin
      if (gate_open && !cfg_word[PW_FREEZE_BIT]) begin
        v.wr        = 1'b1;
        v.wpage     = PAGE_AW'(PW_PAGE);
        v.wdata     = data;
        v.upd_reply = 1'b1;
        v.rkind     = RPL_ACK;
      end
    end else if (cmd == OP_HALT && n0) begin
      v.halt = 1'b1;
    end else if (cmd == OP_CHKPW && n4) begin
      if (data == pw_word) begin
        v.open_gate = 1'b1;
        v.upd_reply = 1'b1;
        v.rkind     = RPL_ACK;
      end
    end else begin
      v.legal = 1'b0;
    end
    if (!v.legal) begin
      v.upd_reply = 1'b1;
      v.rkind     = RPL_ID;
      v.rpage     = '0;
    end
  end
endmodule

// File: rtl/tag_page_file.sv
module tag_page_file
  import tagctl_pkg::*;
#(
  parameter int NPAGES = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PAGE_AW-1:0] waddr,
  input  logic [PAGE_W-1:0]  wdata,
  input  logic [PAGE_AW-1:0] raddr,
  output logic [PAGE_W-1:0]  rdata,
  output logic [PAGE_W-1:0]  cfg_word,
  output logic [PAGE_W-1:0]  pw_word
);
  logic [PAGE_W-1:0] pg [NPAGES];

  for (genvar i = 0; i < NPAGES; i++) begin : g_pg
    logic [PAGE_W-1:0] q;
    logic              en;
    assign en = we && (waddr == PAGE_AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign pg[i] = q;
  end

  assign rdata    = (32'(raddr) < NPAGES) ? pg[raddr] : '0;
  assign cfg_word = pg[CFG_PAGE];
  assign pw_word  = pg[PW_PAGE];
endmodule

// File: rtl/tag_cmd_ctrl.sv
module tag_cmd_ctrl
  import tagctl_pkg::*;
#(
  parameter int NPAGES = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_byte,
  input  logic        rx_vld,
  input  logic        rx_end,
  input  logic        rx_bad,
  output logic [1:0]  reply_kind,
  output logic [3:0]  reply_page,
  output logic [31:0] reply_data,
  output logic        wr_stb,
  output logic [3:0]  wr_page,
  output logic [31:0] wr_data
);
  localparam int DBYTES = PAGE_W / 8;
  localparam int CW     = $clog2(DBYTES + 3);

  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic                has_cmd;
  logic [7:0]          cmd;
  logic [PAGE_W-1:0]   data;
  logic [CW-1:0]       ndata;
  logic [PAGE_W-1:0]   cfg_word, pw_word, rdata;
  verdict_t            v;

  reply_e              kind_q, kind_n;
  logic [PAGE_AW-1:0]  rpage_q, rpage_n;
  logic                gate_q, gate_n, pwok_q, pwok_n, seen_q, seen_n, halt_q, halt_n;
  logic                stb_q, stb_n;
  logic [PAGE_AW-1:0]  wpage_q, wpage_n;
  logic [PAGE_W-1:0]   wdata_q, wdata_n;
  logic                act, fire;

  tag_frame_collect #(.DBYTES(DBYTES)) u_col (
    .clk(clk), .rst_n(rs_n), .rx_byte(rx_byte), .rx_vld(rx_vld),
    .rx_end(rx_end), .rx_bad(rx_bad), .has_cmd(has_cmd), .cmd(cmd),
    .data(data), .ndata(ndata)
  );

  tag_cmd_judge #(.NPAGES(NPAGES), .CW(CW)) u_jdg (
    .has_cmd(has_cmd), .cmd(cmd), .data(data), .ndata(ndata),
    .cfg_word(cfg_word), .pw_word(pw_word), .gate_on(gate_q),
    .pw_ok(pwok_q), .wr_seen(seen_q), .v(v)
  );

  assign act  = rx_end && !halt_q;
  assign fire = act && v.wr;

  tag_page_file #(.NPAGES(NPAGES)) u_mem (
    .clk(clk), .rst_n(rs_n), .we(fire), .waddr(v.wpage), .wdata(v.wdata),
    .raddr(rpage_q), .rdata(rdata), .cfg_word(cfg_word), .pw_word(pw_word)
  );

  always_comb begin
    kind_n  = kind_q;
    rpage_n = rpage_q;
    gate_n  = gate_q;
    pwok_n  = pwok_q;
    seen_n  = seen_q;
    halt_n  = halt_q;
    stb_n   = fire;
    wpage_n = fire ? v.wpage : wpage_q;
    wdata_n = fire ? v.wdata : wdata_q;
    if (act) begin
      if (v.upd_reply) begin
        kind_n  = v.rkind;
        rpage_n = v.rpage;
      end
      if (v.open_gate) pwok_n = 1'b1;
      if (v.mark_wr)   seen_n = 1'b1;
      if (!v.legal)    gate_n = cfg_word[GATE_BIT];
      if (v.halt) begin
        halt_n = 1'b1;
        kind_n = RPL_SILENT;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      kind_q  <= RPL_ID;
      rpage_q <= '0;
      gate_q  <= 1'b0;
      pwok_q  <= 1'b0;
      seen_q  <= 1'b0;
      halt_q  <= 1'b0;
      stb_q   <= 1'b0;
      wpage_q <= '0;
      wdata_q <= '0;
    end else begin
      kind_q  <= kind_n;
      rpage_q <= rpage_n;
      gate_q  <= gate_n;
      pwok_q  <= pwok_n;
      seen_q  <= seen_n;
      halt_q  <= halt_n;
      stb_q   <= stb_n;
      wpage_q <= wpage_n;
      wdata_q <= wdata_n;
    end
  end

  assign reply_kind = kind_q;
  assign reply_page = rpage_q;
  assign reply_data = (kind_q == RPL_PAGE) ? rdata : '0;
  assign wr_stb     = stb_q;
  assign wr_page    = wpage_q;
  assign wr_data    = wdata_q;

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rs_n)
    (($past(cfg_word[7:0]) & ~cfg_word[7:0]) == 8'h00));

  p_lock_after_write_r4: assert property (@(posedge clk) disable iff (!rs_n)
    (cfg_word[7:0] != $past(cfg_word[7:0])) |-> $past(seen_q));

  p_no_locked_write_r3: assert property (@(posedge clk) disable iff (!rs_n)
    (stb_q && wpage_q < 4'd8) |-> !cfg_word[wpage_q[2:0]]);

  p_no_pw_reply_r2: assert property (@(posedge clk) disable iff (!rs_n)
    (kind_q == RPL_PAGE) |-> (32'(rpage_q) != PW_PAGE));

  p_halt_silent_r11: assert property (@(posedge clk) disable iff (!rs_n)
    halt_q |-> (kind_q == RPL_SILENT && !stb_q));
endmodule

// File: tb/sim_tag_cmd_ctrl.sv
module sim_tag_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rx_byte;
  logic        rx_vld, rx_end, rx_bad;
  logic [1:0]  reply_kind;
  logic [3:0]  reply_page;
  logic [31:0] reply_data;
  logic        wr_stb;
  logic [3:0]  wr_page;
  logic [31:0] wr_data;

  tag_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_vld(rx_vld),
    .rx_end(rx_end), .rx_bad(rx_bad), .reply_kind(reply_kind),
    .reply_page(reply_page), .reply_data(reply_data), .wr_stb(wr_stb),
    .wr_page(wr_page), .wr_data(wr_data)
  );

  always #4 clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  bit    cmp_on = 0, finished = 0;
  string cur_req = "R1";

  logic [31:0] m_mem [10];
  int          m_kind, m_page;
  bit          m_gate, m_pwok, m_seen, m_halt, m_wr;
  logic [3:0]  m_wpage;
  logic [31:0] m_wdata;

  task automatic model_reset();
    for (int i = 0; i < 10; i++) m_mem[i] = 32'h0;
    m_kind = 0; m_page = 0; m_gate = 0; m_pwok = 0; m_seen = 0;
    m_halt = 0; m_wr = 0; m_wpage = 0; m_wdata = 0;
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (cmp_on && !finished) begin
      chk(cur_req, {30'h0, reply_kind}, m_kind);
      chk(cur_req, {28'h0, reply_page}, m_page);
      chk(cur_req, reply_data, (m_kind == 1) ? m_mem[m_page] : 32'h0);
      chk(cur_req, {31'h0, wr_stb}, {31'h0, m_wr});
      if (m_wr) begin
        chk(cur_req, {28'h0, wr_page}, {28'h0, m_wpage});
        chk(cur_req, wr_data, m_wdata);
      end
    end
  end

  task automatic model_apply(int n, logic [7:0] b [5], bit bad);
    logic [7:0]  c;
    logic [31:0] d;
    bit legal, open, wr;
    int pg, nd;
    m_wr = 0;
    if (bad || m_halt) return;
    c = b[0]; d = {b[4], b[3], b[2], b[1]};
    nd = n - 1; legal = 1; wr = 0; pg = 0;
    open = !m_gate || m_pwok;
    if (n == 0) legal = 0;
    else if (c >= 8'h80 && c <= 8'h8F && nd == 0) begin
      if (c - 8'h80 > 9) legal = 0;
      else if (c - 8'h80 != 9 && open) begin m_kind = 1; m_page = c - 8'h80; end
    end else if (c >= 8'h40 && c <= 8'h47 && nd == 4) begin
      pg = c - 8'h40;
      if (open && !m_mem[8][pg]) begin
        wr = 1; m_seen = 1; m_kind = 1; m_page = pg;
      end
    end else if (c == 8'hC0 && nd == 4 && b[2] == 8'hAA && b[3] == 8'hAA && b[4] == 8'hAA) begin
      if (open && m_seen) begin
        pg = 8; d = m_mem[8] | {24'h0, b[1]}; wr = 1; m_kind = 1; m_page = 8;
      end
    end else if (c == 8'hC8 && nd == 4 && b[1] == 8'hAA) begin
      if (open && !m_mem[8][11]) begin
        pg = 8; d = {b[4], b[3], b[2], m_mem[8][7:0]}; wr = 1; m_kind = 1; m_page = 8;
      end
    end else if (c == 8'hE0 && nd == 4) begin
      if (open && !m_mem[8][10]) begin pg = 9; wr = 1; m_kind = 2; end
    end else if (c == 8'h18 && nd == 0) begin
      m_halt = 1; m_kind = 3;
    end else if (c == 8'h38 && nd == 4) begin
      if (d == m_mem[9]) begin m_pwok = 1; m_kind = 2; end
    end else legal = 0;
    if (!legal) begin m_kind = 0; m_page = 0; m_gate = m_mem[8][8]; end
    if (wr) begin
      m_mem[pg] = d; m_wr = 1; m_wpage = 4'(pg); m_wdata = d;
    end
  endtask

  task automatic frame(int n, logic [7:0] b0, logic [7:0] b1 = 0, logic [7:0] b2 = 0,
                       logic [7:0] b3 = 0, logic [7:0] b4 = 0, bit bad = 0);
    logic [7:0] b [5];
    b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3; b[4] = b4;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_byte = (i < 5) ? b[i] : 8'h5A; rx_vld = 1'b1;
    end
    @(negedge clk); rx_vld = 1'b0;
    if (bad) rx_bad = 1'b1; else rx_end = 1'b1;
    @(negedge clk); rx_end = 1'b0; rx_bad = 1'b0;
    model_apply(n, b, bad);
    @(negedge clk); m_wr = 0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    cmp_on = 0;
    rst_n = 1'b0; rx_byte = 0; rx_vld = 0; rx_end = 0; rx_bad = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual running expected done");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    cur_req = "R1";
    @(negedge clk); #2;
    chk("R1", {30'h0, reply_kind}, 0);
    chk("R1", {31'h0, wr_stb}, 0);
    cur_req = "R4"; frame(5, 8'hC0, 8'h04, 8'hAA, 8'hAA, 8'hAA);
    #2 chk("R4", {30'h0, reply_kind}, 0);
    cur_req = "R2"; frame(1, 8'h83);
    #2 chk("R1", reply_data, 0);
    cur_req = "R3"; frame(5, 8'h42, 8'h11, 8'h22, 8'h33, 8'h44);
    #2 chk("R3", reply_data, 32'h44332211);
    frame(5, 8'h40, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    cur_req = "R2"; frame(1, 8'h82);
    #2 chk("R2", reply_data, 32'h44332211);
    frame(1, 8'h89);
    #2 chk("R2", {28'h0, reply_page}, 2);
    cur_req = "R9"; frame(1, 8'h8C);
    #2 chk("R9", {30'h0, reply_kind}, 0);
    cur_req = "R4"; frame(5, 8'hC0, 8'h04, 8'hAA, 8'hAA, 8'hAA);
    frame(5, 8'hC0, 8'h01, 8'hAA, 8'hAA, 8'hAA);
    #2 chk("R4", reply_data, 32'h00000005);
    frame(5, 8'hC0, 8'h00, 8'hAA, 8'hAA, 8'hAA);
    #2 chk("R4", reply_data, 32'h00000005);
    cur_req = "R12"; frame(5, 8'h42, 8'h99, 8'h99, 8'h99, 8'h99);
    #2 chk("R12", {28'h0, reply_page}, 8);
    cur_req = "R5"; frame(5, 8'hC8, 8'hAA, 8'h01, 8'h00, 8'h00);
    #2 chk("R5", reply_data, 32'h00000105);
    cur_req = "R8"; frame(1, 8'h80);
    #2 chk("R8", reply_data, 32'hD4C3B2A1);
    frame(1, 8'h55);
    frame(1, 8'h80);
    #2 chk("R8", {30'h0, reply_kind}, 0);
    cur_req = "R7"; frame(5, 8'hE0, 8'h01, 8'h02, 8'h03, 8'h04);
    frame(5, 8'h38, 8'h44, 8'h33, 8'h22, 8'h11);
    #2 chk("R7", {30'h0, reply_kind}, 0);
    frame(5, 8'h38, 8'h00, 8'h00, 8'h00, 8'h00);
    #2 chk("R7", {30'h0, reply_kind}, 2);
    frame(1, 8'h80);
    #2 chk("R7", reply_data, 32'hD4C3B2A1);
    cur_req = "R6"; frame(5, 8'hE0, 8'hEF, 8'hBE, 8'hAD, 8'hDE);
    #2 chk("R6", {30'h0, reply_kind}, 2);
    frame(1, 8'h89);
    frame(5, 8'h38, 8'hEF, 8'hBE, 8'hAD, 8'hDE);
    frame(5, 8'hC8, 8'hAA, 8'h05, 8'h00, 8'h00);
    frame(5, 8'hE0, 8'h00, 8'h00, 8'h00, 8'h00);
    #2 chk("R6", {30'h0, reply_kind}, 1);
    cur_req = "R5"; frame(5, 8'hC8, 8'hAA, 8'h0D, 8'h00, 8'h00);
    frame(5, 8'hC8, 8'hAA, 8'h00, 8'h00, 8'h00);
    frame(1, 8'h88);
    #2 chk("R5", reply_data, 32'h00000D05);
    cur_req = "R9"; frame(2, 8'h81, 8'h00);
    frame(1, 8'h81);
    frame(4, 8'h41, 8'h01, 8'h02, 8'h03);
    #2 chk("R9", {30'h0, reply_kind}, 0);
    frame(1, 8'h81);
    frame(5, 8'hC0, 8'h02, 8'hAB, 8'hAA, 8'hAA);
    #2 chk("R9", {30'h0, reply_kind}, 0);
    frame(6, 8'h41, 8'h01, 8'h02, 8'h03, 8'h04);
    frame(0, 8'h00);
    #2 chk("R9", {30'h0, reply_kind}, 0);
    cur_req = "R10"; frame(1, 8'h38, 8'hEF, 8'hBE, 8'hAD, 8'hDE);
    frame(5, 8'h38, 8'hEF, 8'hBE, 8'hAD, 8'hDE);
    frame(5, 8'h41, 8'h77, 8'h77, 8'h77, 8'h77, 1);
    #2 chk("R10", {30'h0, reply_kind}, 2);
    frame(1, 8'h81);
    #2 chk("R10", reply_data, 0);
    cur_req = "R11"; frame(1, 8'h18);
    #2 chk("R11", {30'h0, reply_kind}, 3);
    frame(5, 8'h43, 8'h01, 8'h01, 8'h01, 8'h01);
    frame(1, 8'h55);
    #2 chk("R11", {30'h0, reply_kind}, 3);
    do_reset();
    cur_req = "R1"; frame(1, 8'h82);
    #2 chk("R1", reply_data, 0);
    frame(1, 8'h88);
    #2 chk("R1", reply_data, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule